// File: doc/BRIEF.md
# Operand Addressing-Mode Fetch Unit

This unit supplies the source operand for a two-operand register-memory instruction of the form `Rd += operand`. It takes one request at a time. A request carries a mode code, a destination register index, base and index register indices, a constant field that serves as either a displacement or an immediate, and a scale selector. The unit drives the read indices of three register-file read ports and takes the values returned in the same cycle. From these it forms the effective address and performs at most two word reads over a valid/ready memory port. It then ends the request with one of three outcomes: a completed result, an alignment fault, or a mode error.

A completed result provides the operand and the destination write-back `Rd + operand`. In the auto-stepping modes it also provides the base-register update. Memory is byte addressed and one word is `DATA_W/8` bytes (4 by default). The auto modes step the base register by this word size. When the alignment check is built in, any word read at an address that is not a multiple of the word size is refused. In that case no read is issued for it and nothing is written back.

Top module: `opnd_fetch`

## Requirements
- R1: After reset `req_ready` is 1 and `done`, `fault`, `mode_err`, `mem_valid`, `rd_we` and `base_we` are all 0.
- R2: Mode 0 (register) returns the base register value as the operand. Mode 1 (immediate) returns the constant field. Neither mode issues a memory read.
- R3: Mode 2 (displacement) reads at constant + base. Mode 3 (indirect) reads at base. Mode 4 (indexed) reads at base + index. Mode 5 (absolute) reads at the constant. Each returns the word read as the operand, after exactly one read.
- R4: Mode 6 (deferred) first reads at base. It then reads at the word that came back, and returns the second word. The reads occur in that order, and there are exactly two of them.
- R5: Mode 7 (autoincrement) reads at base. With `done` it writes base + word size back to the base register (`base_we`=1, `base_wr_idx`=base index).
- R6: Mode 8 (autodecrement) reads at base − word size and writes that same value back to the base register with `done`.
- R7: Mode 9 (scaled) reads at constant + base + index·2^s, where s is `req_scale` in the range 0..4 (a data size of 1, 2, 4, 8 or 16 bytes). Values of s from 5 to 7 are treated as an illegal mode.
- R8: With the alignment check enabled, a word address whose low two bits are not zero ends the request with a one-cycle `fault`. This applies to a first address and also to a pointer returned by the first deferred read. The misaligned address is not issued, and no register write-back occurs.
- R9: A request is taken only while `req_ready` is 1, and `req_ready` stays 0 until the outcome cycle has passed. While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid` and `mem_addr` stay unchanged.
- R10: `done` is high for exactly one cycle. In that cycle `rd_we` is 1, `rd_wr_idx` is the destination index and `rd_wr_data` is Rd + operand.
- R11: Mode codes 10 to 15 raise `mode_err` for exactly one cycle, with no memory read and no register write-back. Only one of `done`, `fault` and `mode_err` is ever high in a given cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken at this edge |
| req_mode | input | 4 | Addressing-mode code |
| req_rd | input | REG_IDX_W | Destination register index |
| req_base | input | REG_IDX_W | Base register index |
| req_index | input | REG_IDX_W | Index register index |
| req_konst | input | DATA_W | Displacement or immediate field |
| req_scale | input | 3 | Scale exponent for the scaled mode |
| rf_rd_addr | output | REG_IDX_W | Read index, destination port |
| rf_base_addr | output | REG_IDX_W | Read index, base port |
| rf_index_addr | output | REG_IDX_W | Read index, index port |
| rf_rd_data | input | DATA_W | Destination register value |
| rf_base_data | input | DATA_W | Base register value |
| rf_index_data | input | DATA_W | Index register value |
| mem_valid | output | 1 | Word read request |
| mem_ready | input | 1 | Read accepted; data valid this cycle |
| mem_addr | output | DATA_W | Byte address of the read |
| mem_rdata | input | DATA_W | Word returned |
| done | output | 1 | Result cycle |
| operand | output | DATA_W | Resolved operand |
| rd_we | output | 1 | Destination write enable |
| rd_wr_idx | output | REG_IDX_W | Destination write index |
| rd_wr_data | output | DATA_W | Rd + operand |
| base_we | output | 1 | Base register update enable |
| base_wr_idx | output | REG_IDX_W | Base register write index |
| base_wr_data | output | DATA_W | Updated base value |
| fault | output | 1 | Alignment fault cycle |
| mode_err | output | 1 | Illegal mode cycle |

## Verification
Every register and every memory word has a distinct value. A wrong register read, a wrong sum or a swapped operand therefore gives a different address or result. The memory model returns a word that is a function of its address, so the read addresses recorded at the port show both where each read went and the order of the two deferred reads. The scaled mode is run with every exponent from 0 to 4 and then with 5, which separates a missing or off-by-one shift from a wrong legal range. Stalled handshakes, together with misaligned displacement, base and returned-pointer cases, show that the unit waits, refuses the bad address and writes nothing back.

// File: rtl/opnd_fetch_pkg.sv
package opnd_fetch_pkg;

   typedef enum logic [3:0] {
      AM_REG  = 4'd0,
      AM_IMM  = 4'd1,
      AM_DISP = 4'd2,
      AM_IND  = 4'd3,
      AM_IDX  = 4'd4,
      AM_ABS  = 4'd5,
      AM_DEF  = 4'd6,
      AM_AINC = 4'd7,
      AM_ADEC = 4'd8,
      AM_SCL  = 4'd9
   } amode_e;

   typedef struct packed {
      logic use_mem;
      logic two_step;
      logic upd_base;
      logic bad_mode;
   } mode_ctl_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD1  = 3'd1,
      ST_RD2  = 3'd2,
      ST_DONE = 3'd3,
      ST_FLT  = 3'd4,
      ST_ERR  = 3'd5
   } fsm_e;

endpackage

// File: rtl/opnd_agen.sv
module opnd_agen
   import opnd_fetch_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SCALE_W     = 3,
   parameter int MAX_SCL_LOG = 4
) (
   input  logic [3:0]          mode,
   input  logic [DATA_W-1:0]   base_val,
   input  logic [DATA_W-1:0]   index_val,
   input  logic [DATA_W-1:0]   konst,
   input  logic [SCALE_W-1:0]  scale_sel,
   output mode_ctl_t           ctl,
   output logic [DATA_W-1:0]   addr,
   output logic [DATA_W-1:0]   direct,
   output logic [DATA_W-1:0]   wb_val
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

   initial begin
      assert (MAX_SCL_LOG < (1 << SCALE_W))
         else $error("scale selector too narrow for MAX_SCL_LOG");
   end

   logic [DATA_W-1:0] scaled_idx;
   logic              scale_ok;

   assign scaled_idx = index_val << scale_sel;
   assign scale_ok   = (int'(scale_sel) <= MAX_SCL_LOG);

   always_comb begin
      ctl    = '0;
      addr   = '0;
      direct = '0;
      wb_val = base_val;
      case (mode)
         AM_REG:  direct = base_val;
         AM_IMM:  direct = konst;
         AM_DISP: begin ctl.use_mem = 1'b1; addr = konst + base_val; end
         AM_IND:  begin ctl.use_mem = 1'b1; addr = base_val; end
         AM_IDX:  begin ctl.use_mem = 1'b1; addr = base_val + index_val; end
         AM_ABS:  begin ctl.use_mem = 1'b1; addr = konst; end
         AM_DEF: begin
            ctl.use_mem  = 1'b1;
            ctl.two_step = 1'b1;
            addr         = base_val;
         end
         AM_AINC: begin
            ctl.use_mem  = 1'b1;
            ctl.upd_base = 1'b1;
            addr         = base_val;
            wb_val       = base_val + STEP;
         end
         AM_ADEC: begin
            ctl.use_mem  = 1'b1;
            ctl.upd_base = 1'b1;
            addr         = base_val - STEP;
            wb_val       = base_val - STEP;
         end
         AM_SCL: begin
            if (scale_ok) begin
               ctl.use_mem = 1'b1;
               addr        = konst + base_val + scaled_idx;
            end else begin
               ctl.bad_mode = 1'b1;
            end
         end
         default: ctl.bad_mode = 1'b1;
      endcase
   end

endmodule

// File: rtl/opnd_align.sv
module opnd_align #(
   parameter int DATA_W = 32,
   parameter bit CHECK  = 1'b1
) (
   input  logic [DATA_W-1:0] addr,
   output logic              misal
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int LOW_W      = $clog2(WORD_BYTES);

   initial begin
      assert (WORD_BYTES >= 2 && (WORD_BYTES & (WORD_BYTES - 1)) == 0)
         else $error("word size must be a power of two of at least 2 bytes");
   end

   generate
      if (CHECK) begin : g_check
         assign misal = |addr[LOW_W-1:0];
      end else begin : g_nocheck
         logic unused_addr;
         assign unused_addr = ^addr;
         assign misal       = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
   import opnd_fetch_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  mode_ctl_t            ctl,
   input  logic [DATA_W-1:0]    addr,
   input  logic [DATA_W-1:0]    direct,
   input  logic [DATA_W-1:0]    wb_val,
   input  logic                 misal_first,
   input  logic                 misal_ptr,
   input  logic [DATA_W-1:0]    rd_val,
   input  logic [REG_IDX_W-1:0] rd_idx,
   input  logic [REG_IDX_W-1:0] base_idx,
   output logic                 mem_valid,
   input  logic                 mem_ready,
   output logic [DATA_W-1:0]    mem_addr,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic                 done,
   output logic [DATA_W-1:0]    operand,
   output logic                 rd_we,
   output logic [REG_IDX_W-1:0] rd_wr_idx,
   output logic [DATA_W-1:0]    rd_wr_data,
   output logic                 base_we,
   output logic [REG_IDX_W-1:0] base_wr_idx,
   output logic [DATA_W-1:0]    base_wr_data,
   output logic                 fault,
   output logic                 mode_err
);
   fsm_e                 state_q;
   logic [DATA_W-1:0]    addr_q;
   logic [DATA_W-1:0]    opnd_q;
   logic [DATA_W-1:0]    rdv_q;
   logic [DATA_W-1:0]    wbv_q;
   logic [REG_IDX_W-1:0] rdi_q;
   logic [REG_IDX_W-1:0] bsi_q;
   logic                 two_q;
   logic                 upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         opnd_q  <= '0;
         rdv_q   <= '0;
         wbv_q   <= '0;
         rdi_q   <= '0;
         bsi_q   <= '0;
         two_q   <= 1'b0;
         upd_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  rdv_q <= rd_val;
                  wbv_q <= wb_val;
                  rdi_q <= rd_idx;
                  bsi_q <= base_idx;
                  two_q <= ctl.two_step;
                  upd_q <= ctl.upd_base;
                  if (ctl.bad_mode) begin
                     state_q <= ST_ERR;
                  end else if (ctl.use_mem) begin
                     if (misal_first) begin
                        state_q <= ST_FLT;
                     end else begin
                        addr_q  <= addr;
                        state_q <= ST_RD1;
                     end
                  end else begin
                     opnd_q  <= direct;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_RD1: begin
               if (mem_ready) begin
                  if (two_q) begin
                     if (misal_ptr) begin
                        state_q <= ST_FLT;
                     end else begin
                        addr_q  <= mem_rdata;
                        state_q <= ST_RD2;
                     end
                  end else begin
                     opnd_q  <= mem_rdata;
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_RD2: begin
               if (mem_ready) begin
                  opnd_q  <= mem_rdata;
                  state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign mem_valid    = (state_q == ST_RD1) || (state_q == ST_RD2);
   assign mem_addr     = addr_q;
   assign done         = (state_q == ST_DONE);
   assign fault        = (state_q == ST_FLT);
   assign mode_err     = (state_q == ST_ERR);
   assign operand      = opnd_q;
   assign rd_we        = done;
   assign rd_wr_idx    = rdi_q;
   assign rd_wr_data   = rdv_q + opnd_q;
   assign base_we      = done && upd_q;
   assign base_wr_idx  = bsi_q;
   assign base_wr_data = wbv_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R9
   AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R9
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fault, mode_err})); // R11
   AST_ERR_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |=> (req_ready && !mem_valid)); // R11

endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch
   import opnd_fetch_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int REG_IDX_W   = 4,
   parameter int MAX_SCL_LOG = 4,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [3:0]           req_mode,
   input  logic [REG_IDX_W-1:0] req_rd,
   input  logic [REG_IDX_W-1:0] req_base,
   input  logic [REG_IDX_W-1:0] req_index,
   input  logic [DATA_W-1:0]    req_konst,
   input  logic [2:0]           req_scale,
   output logic [REG_IDX_W-1:0] rf_rd_addr,
   output logic [REG_IDX_W-1:0] rf_base_addr,
   output logic [REG_IDX_W-1:0] rf_index_addr,
   input  logic [DATA_W-1:0]    rf_rd_data,
   input  logic [DATA_W-1:0]    rf_base_data,
   input  logic [DATA_W-1:0]    rf_index_data,
   output logic                 mem_valid,
   input  logic                 mem_ready,
   output logic [DATA_W-1:0]    mem_addr,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic                 done,
   output logic [DATA_W-1:0]    operand,
   output logic                 rd_we,
   output logic [REG_IDX_W-1:0] rd_wr_idx,
   output logic [DATA_W-1:0]    rd_wr_data,
   output logic                 base_we,
   output logic [REG_IDX_W-1:0] base_wr_idx,
   output logic [DATA_W-1:0]    base_wr_data,
   output logic                 fault,
   output logic                 mode_err
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int LOW_W      = $clog2(WORD_BYTES);

   mode_ctl_t         ctl;
   logic [DATA_W-1:0] ea;
   logic [DATA_W-1:0] direct;
   logic [DATA_W-1:0] wb_val;
   logic              misal_first;
   logic              misal_ptr;

   assign rf_rd_addr    = req_rd;
   assign rf_base_addr  = req_base;
   assign rf_index_addr = req_index;

   opnd_agen #(
      .DATA_W      (DATA_W),
      .SCALE_W     (3),
      .MAX_SCL_LOG (MAX_SCL_LOG)
   ) u_agen (
      .mode      (req_mode),
      .base_val  (rf_base_data),
      .index_val (rf_index_data),
      .konst     (req_konst),
      .scale_sel (req_scale),
      .ctl       (ctl),
      .addr      (ea),
      .direct    (direct),
      .wb_val    (wb_val)
   );

   opnd_align #(.DATA_W(DATA_W), .CHECK(ALIGN_CHECK)) u_align_ea (
      .addr  (ea),
      .misal (misal_first)
   );

   opnd_align #(.DATA_W(DATA_W), .CHECK(ALIGN_CHECK)) u_align_ptr (
      .addr  (mem_rdata),
      .misal (misal_ptr)
   );

   opnd_ctrl #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .ctl          (ctl),
      .addr         (ea),
      .direct       (direct),
      .wb_val       (wb_val),
      .misal_first  (misal_first),
      .misal_ptr    (misal_ptr),
      .rd_val       (rf_rd_data),
      .rd_idx       (req_rd),
      .base_idx     (req_base),
      .mem_valid    (mem_valid),
      .mem_ready    (mem_ready),
      .mem_addr     (mem_addr),
      .mem_rdata    (mem_rdata),
      .done         (done),
      .operand      (operand),
      .rd_we        (rd_we),
      .rd_wr_idx    (rd_wr_idx),
      .rd_wr_data   (rd_wr_data),
      .base_we      (base_we),
      .base_wr_idx  (base_wr_idx),
      .base_wr_data (base_wr_data),
      .fault        (fault),
      .mode_err     (mode_err)
   );

   generate
      if (ALIGN_CHECK) begin : g_align_sva
         AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            mem_valid |-> (mem_addr[LOW_W-1:0] == '0)); // R8
         AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
            fault |=> !mem_valid); // R8
      end
   endgenerate

endmodule

// File: tb/opnd_fetch_tb.sv
`timescale 1ns/1ps
module opnd_fetch_tb;
   localparam int DW = 32;
   localparam int RW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [3:0]    req_mode = '0;
   logic [RW-1:0] req_rd = '0, req_base = '0, req_index = '0;
   logic [DW-1:0] req_konst = '0;
   logic [2:0]    req_scale = '0;
   logic [RW-1:0] rf_rd_addr, rf_base_addr, rf_index_addr;
   logic [DW-1:0] rf_rd_data, rf_base_data, rf_index_data;
   logic          mem_valid, mem_ready;
   logic [DW-1:0] mem_addr, mem_rdata;
   logic          done, rd_we, base_we, fault, mode_err;
   logic [DW-1:0] operand, rd_wr_data, base_wr_data;
   logic [RW-1:0] rd_wr_idx, base_wr_idx;

   always #4 clk = ~clk;

   logic [DW-1:0] regs [16];
   assign rf_rd_data    = regs[rf_rd_addr];
   assign rf_base_data  = regs[rf_base_addr];
   assign rf_index_data = regs[rf_index_addr];

   function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
      if (a == 32'h0000_0800) return 32'h0000_2002;
      return a * 3 + 32'h0000_1000;
   endfunction

   int stall_cfg = 0;
   int stall_ctr = 0;
   assign mem_ready = mem_valid && (stall_ctr >= stall_cfg);
   assign mem_rdata = memf(mem_addr);

   int            log_n = 0;
   logic [DW-1:0] log_a [64];
   always @(posedge clk) begin
      if (mem_valid && !mem_ready) stall_ctr <= stall_ctr + 1;
      else stall_ctr <= 0;
      if (mem_valid && mem_ready) begin
         log_a[log_n % 64] <= mem_addr;
         log_n <= log_n + 1;
      end
   end

   opnd_fetch u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_rd(req_rd), .req_base(req_base),
      .req_index(req_index), .req_konst(req_konst), .req_scale(req_scale),
      .rf_rd_addr(rf_rd_addr), .rf_base_addr(rf_base_addr),
      .rf_index_addr(rf_index_addr), .rf_rd_data(rf_rd_data),
      .rf_base_data(rf_base_data), .rf_index_data(rf_index_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .done(done), .operand(operand), .rd_we(rd_we),
      .rd_wr_idx(rd_wr_idx), .rd_wr_data(rd_wr_data), .base_we(base_we),
      .base_wr_idx(base_wr_idx), .base_wr_data(base_wr_data),
      .fault(fault), .mode_err(mode_err)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // result of the last request
   int            r_kind;   // 0 done, 1 fault, 2 mode_err, 3 timeout
   logic [DW-1:0] r_opnd, r_rdd, r_bdata;
   logic [RW-1:0] r_rdi, r_bidx;
   logic          r_rdwe, r_bwe, r_busy_rdy, r_pulse_ok;
   int            r_nmem, r_start;

   task automatic issue(input logic [3:0] m, input int rd, input int b,
                        input int x, input logic [DW-1:0] k, input int s);
      @(negedge clk);
      req_mode = m; req_rd = RW'(rd); req_base = RW'(b); req_index = RW'(x);
      req_konst = k; req_scale = 3'(s); req_valid = 1'b1;
      r_start = log_n;
      @(negedge clk);
      req_valid = 1'b0;
      r_busy_rdy = req_ready;
      r_kind = 3;
      for (int c = 0; c < 40; c++) begin
         if (done || fault || mode_err) break;
         @(negedge clk);
      end
      if (done) r_kind = 0;
      else if (fault) r_kind = 1;
      else if (mode_err) r_kind = 2;
      r_opnd = operand; r_rdd = rd_wr_data; r_rdi = rd_wr_idx; r_rdwe = rd_we;
      r_bwe = base_we; r_bidx = base_wr_idx; r_bdata = base_wr_data;
      @(negedge clk);
      r_pulse_ok = !done && !fault && !mode_err;
      r_nmem = log_n - r_start;
   endtask

   task automatic expect_done(input string tag, input logic [DW-1:0] exp_op,
                              input int rd, input int exp_nmem);
      chk(r_kind == 0, {tag, " outcome"}, DW'(r_kind), 0);
      chk(r_opnd == exp_op, {tag, " operand"}, r_opnd, exp_op);
      chk(r_rdwe && r_rdi == RW'(rd) && r_rdd == regs[rd] + exp_op,
          {tag, " R10 rd write"}, r_rdd, regs[rd] + exp_op);
      chk(r_nmem == exp_nmem, {tag, " read count"}, DW'(r_nmem), DW'(exp_nmem));
      chk(!r_busy_rdy, {tag, " R9 ready while busy"}, DW'(r_busy_rdy), 0);
      chk(r_pulse_ok, {tag, " R10 single pulse"}, DW'(r_pulse_ok), 1);
   endtask

   task automatic t_reset;
      chk(req_ready && !done && !fault && !mode_err && !mem_valid && !rd_we && !base_we,
          "R1 reset state", {26'd0, req_ready, done, fault, mode_err, mem_valid, base_we},
          32'h20);
   endtask

   task automatic t_direct;
      issue(4'd0, 2, 3, 0, 32'h0, 0);
      expect_done("R2 register", regs[3], 2, 0);
      issue(4'd1, 4, 0, 0, 32'h55, 0);
      expect_done("R2 immediate", 32'h55, 4, 0);
   endtask

   task automatic t_single;
      logic [DW-1:0] a;
      stall_cfg = 3;
      a = regs[4] + 32'h20;
      issue(4'd2, 1, 4, 0, 32'h20, 0);
      expect_done("R3 displacement stalled", memf(a), 1, 1);
      chk(log_a[r_start % 64] == a, "R3 R9 displacement addr", log_a[r_start % 64], a);
      stall_cfg = 0;
      issue(4'd3, 1, 5, 0, 32'h0, 0);
      expect_done("R3 indirect", memf(regs[5]), 1, 1);
      chk(log_a[r_start % 64] == regs[5], "R3 indirect addr", log_a[r_start % 64], regs[5]);
      a = regs[5] + regs[6];
      issue(4'd4, 2, 5, 6, 32'h0, 0);
      expect_done("R3 indexed", memf(a), 2, 1);
      chk(log_a[r_start % 64] == a, "R3 indexed addr", log_a[r_start % 64], a);
      issue(4'd5, 3, 0, 0, 32'h4000, 0);
      expect_done("R3 absolute", memf(32'h4000), 3, 1);
      chk(log_a[r_start % 64] == 32'h4000, "R3 absolute addr", log_a[r_start % 64], 32'h4000);
   endtask

   task automatic t_deferred;
      logic [DW-1:0] p;
      stall_cfg = 2;
      p = memf(regs[7]);
      issue(4'd6, 1, 7, 0, 32'h0, 0);
      expect_done("R4 deferred", memf(p), 1, 2);
      chk(log_a[r_start % 64] == regs[7], "R4 first read", log_a[r_start % 64], regs[7]);
      chk(log_a[(r_start + 1) % 64] == p, "R4 second read", log_a[(r_start + 1) % 64], p);
      stall_cfg = 0;
   endtask

   task automatic t_auto;
      issue(4'd7, 1, 8, 0, 32'h0, 0);
      expect_done("R5 autoincrement", memf(regs[8]), 1, 1);
      chk(log_a[r_start % 64] == regs[8], "R5 read addr", log_a[r_start % 64], regs[8]);
      chk(r_bwe && r_bidx == 4'd8 && r_bdata == regs[8] + 4, "R5 base update",
          r_bdata, regs[8] + 4);
      issue(4'd8, 1, 9, 0, 32'h0, 0);
      expect_done("R6 autodecrement", memf(regs[9] - 4), 1, 1);
      chk(log_a[r_start % 64] == regs[9] - 4, "R6 read addr", log_a[r_start % 64], regs[9] - 4);
      chk(r_bwe && r_bidx == 4'd9 && r_bdata == regs[9] - 4, "R6 base update",
          r_bdata, regs[9] - 4);
   endtask

   task automatic t_scaled;
      for (int s = 0; s <= 4; s++) begin
         logic [DW-1:0] a;
         a = 32'h8 + regs[10] + (regs[11] << s);
         issue(4'd9, 2, 10, 11, 32'h8, s);
         expect_done("R7 scaled", memf(a), 2, 1);
         chk(log_a[r_start % 64] == a, "R7 scaled addr", log_a[r_start % 64], a);
      end
      issue(4'd9, 2, 10, 11, 32'h8, 5);
      chk(r_kind == 2 && r_nmem == 0 && !r_rdwe, "R7 scale 5 rejected", DW'(r_kind), 2);
   endtask

   task automatic t_align;
      issue(4'd2, 1, 4, 0, 32'h22, 0);
      chk(r_kind == 1, "R8 misaligned displacement fault", DW'(r_kind), 1);
      chk(r_nmem == 0 && !r_rdwe && !r_bwe, "R8 no read no write", DW'(r_nmem), 0);
      chk(r_pulse_ok, "R8 fault one cycle", DW'(r_pulse_ok), 1);
      issue(4'd6, 1, 15, 0, 32'h0, 0);
      chk(r_kind == 1 && r_nmem == 1, "R8 misaligned pointer", DW'(r_nmem), 1);
      issue(4'd7, 1, 14, 0, 32'h0, 0);
      chk(r_kind == 1 && !r_bwe && r_nmem == 0, "R8 autoincrement no base update",
          DW'(r_bwe), 0);
   endtask

   task automatic t_illegal;
      for (int m = 10; m <= 15; m += 5) begin
         issue(4'(m), 1, 3, 0, 32'h0, 0);
         chk(r_kind == 2, "R11 illegal mode error", DW'(r_kind), 2);
         chk(r_nmem == 0 && !r_rdwe && !r_bwe && r_pulse_ok, "R11 quiet single pulse",
             DW'(r_nmem), 0);
      end
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=done", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) regs[i] = 32'h1000 + 32'(i) * 32'h40;
      regs[14] = 32'h0000_3001;
      regs[15] = 32'h0000_0800;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_single();
      t_deferred();
      t_auto();
      t_scaled();
      t_align();
      t_illegal();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule